// File: doc/BRIEF.md
# Timed NAND Flash Bus Controller

This block connects a simple 32-bit register bus to an 8-bit NAND flash device. Software picks the flash bus cycle it wants by the register it touches. A write to the command register or the address register produces one complete, timed write cycle with the matching latch-enable line raised. A write to the data register produces a plain data write cycle. A read of the data register produces a read-strobe pulse, and the byte that the flash drives is returned as the read result. Chip enable and the controller enable are held in a control register. A status register shows the ready/busy pin after synchronisation.

The three timing fields in the configuration register set every cycle in units of the controller clock. Those fields are the latch setup, the strobe low width and the hold after the strobe. While a flash cycle runs, the host bus is held in wait. A new access is taken only when the controller is idle, and strobes that arrive during a cycle are dropped. A typical use is identification: select the chip, issue command 0x90 and address 0x00, then read four bytes.

Top module: `nand_if_ctrl`

## Requirements
- R1: After synchronous reset, nCE, nWE and nRE are high, CLE, ALE and the I/O output enable are low, and bus_ready is high. The configuration register (offset 0x00) reads 0. The control register (offset 0x04) reads 0x2.
- R2: Control bit 0 enables the controller and control bit 1 deasserts chip enable. nCE is low only when bit 0 is 1 and bit 1 is 0. The register reads back these two bits, and all other bits read 0.
- R3: The configuration register holds the setup count S in bits [14:12], the strobe field P in bits [10:8] and the hold field H in bits [6:4]. A readback returns only these fields, and all other bits read 0.
- R4: A write to offset 0x08 while enabled runs a command cycle. CLE is high and ALE is low for the whole cycle. The I/O output enable is high, and the I/O bus carries bits [7:0] of the written word. nWE is low only during the strobe phase.
- R5: A write to offset 0x0C while enabled runs the same cycle as R4, with ALE high and CLE low.
- R6: A write to offset 0x10 while enabled runs the same cycle as R4 with CLE and ALE both low.
- R7: A read of offset 0x10 while enabled keeps the output enable low and drives nRE low during the strobe phase. The I/O input is captured at the clock edge where nRE rises. The read result is that byte in bits [7:0], with the upper bits 0.
- R8: A flash cycle sampled after the accepting edge consists of three phases in order. The setup phase lasts S cycles, the strobe phase lasts P+1 cycles and the hold phase lasts H+1 cycles. bus_ready is low for exactly S+P+H+2 cycles and then returns high, and at that point the read result is valid.
- R9: A strobe that arrives while bus_ready is low is ignored. The running cycle keeps its byte and its kind, and no second cycle follows.
- R10: While control bit 0 is 0, accesses to offsets 0x08, 0x0C and 0x10 cause no pin activity and no wait. nCE, nWE and nRE stay high, and a data read returns 0.
- R11: Status register (offset 0x20) bit 0 follows the ready/busy pin (0 busy, 1 ready) within three clock cycles. The other status bits read 0.
- R12: After chip enable, command 0x90 and address 0x00, four data reads return 0xEC, 0xDA, 0x10 and 0x95 in that order from the bench flash model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_wr | input | 1 | 1 selects a write access, 0 selects a read access |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read result, valid once bus_ready is high after the access |
| bus_ready | output | 1 | High when idle; low while a flash cycle runs |
| fl_nce | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_nwe | output | 1 | Write strobe, active low |
| fl_nre | output | 1 | Read strobe, active low |
| fl_io_out | output | IOW | Byte driven toward the flash |
| fl_io_oe | output | 1 | Output enable for the I/O bus |
| fl_io_in | input | IOW | Byte returned by the flash |
| fl_rnb | input | 1 | Ready/busy pin from the flash, 1 = ready |

## Verification
Suppose the phase counter holds a wrong value or the phase register is corrupted. The visible result is a strobe that is too long or too short, or a bus_ready that returns early or late. The bench reference model compares the pins on every cycle of a flash cycle, so such a fault shows in the very cycle where the edge lands in the wrong place. If the latched kind or byte is wrong, CLE, ALE, the output enable or the I/O byte differs from the model from the first cycle after the accepting edge. If the capture point is wrong, the identification bytes come back shifted, and this shows at the first data read.

// File: rtl/nand_if_pkg.sv
// Shared definitions for the NAND flash bus controller.
// Assumes byte offsets on the host bus; register field positions are fixed here.
package nand_if_pkg;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WDATA = 2'd2,
        OP_RDATA = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    localparam logic [7:0] OFF_CFG  = 8'h00;
    localparam logic [7:0] OFF_CTRL = 8'h04;
    localparam logic [7:0] OFF_CMD  = 8'h08;
    localparam logic [7:0] OFF_ADDR = 8'h0C;
    localparam logic [7:0] OFF_DATA = 8'h10;
    localparam logic [7:0] OFF_STAT = 8'h20;

    localparam int SETUP_LSB   = 12;
    localparam int STROBE_LSB  = 8;
    localparam int HOLD_LSB    = 4;
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_CE_BIT = 1;

endpackage

// File: rtl/nand_if_sync.sv
// Multi-stage synchroniser for the asynchronous ready/busy pin.
// Assumes STAGES >= 1; the reset value is 0 (busy), the safe reading.
module nand_if_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= d;
            end
        end else begin : g_many
            // Shift the pin value through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = shreg[STAGES-1];

endmodule

// File: rtl/nand_if_regs.sv
// Configuration and control registers plus read-word assembly.
// Assumes TW <= 4 so that the three timing fields do not overlap.
module nand_if_regs
    import nand_if_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          ctrl_we,
    input  logic [DW-1:0] wdata,
    input  logic          rnb_s,
    output logic [TW-1:0] t_setup,
    output logic [TW-1:0] t_strobe,
    output logic [TW-1:0] t_hold,
    output logic          en,
    output logic          ce_off,
    output logic [DW-1:0] cfg_word,
    output logic [DW-1:0] ctrl_word,
    output logic [DW-1:0] stat_word
);

    localparam logic [DW-1:0] FIELD  = DW'((1 << TW) - 1);
    localparam logic [DW-1:0] USED   = (FIELD << SETUP_LSB) | (FIELD << STROBE_LSB) |
                                       (FIELD << HOLD_LSB) | DW'(3);

    logic unused_wdata;
    assign unused_wdata = ^(wdata & ~USED);

    // Timing field storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_setup  <= '0;
            t_strobe <= '0;
            t_hold   <= '0;
        end else if (cfg_we) begin
            t_setup  <= wdata[SETUP_LSB  +: TW];
            t_strobe <= wdata[STROBE_LSB +: TW];
            t_hold   <= wdata[HOLD_LSB   +: TW];
        end
    end

    // Enable and chip-enable bits; chip deselected at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            ce_off <= 1'b1;
        end else if (ctrl_we) begin
            en     <= wdata[CTRL_EN_BIT];
            ce_off <= wdata[CTRL_CE_BIT];
        end
    end

    // Assemble the readback words.
    always_comb begin
        cfg_word = '0;
        cfg_word[SETUP_LSB  +: TW] = t_setup;
        cfg_word[STROBE_LSB +: TW] = t_strobe;
        cfg_word[HOLD_LSB   +: TW] = t_hold;
        ctrl_word = '0;
        ctrl_word[CTRL_EN_BIT] = en;
        ctrl_word[CTRL_CE_BIT] = ce_off;
        stat_word = '0;
        stat_word[0] = rnb_s;
    end

    assert_cfg_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (t_strobe == $past(wdata[STROBE_LSB +: TW])));

endmodule

// File: rtl/nand_if_seq.sv
// Flash bus cycle sequencer: setup, strobe and hold phases per access.
// Assumes start is raised only while busy is low; timing is latched at start.
module nand_if_seq
    import nand_if_pkg::*;
#(
    parameter int TW  = 3,
    parameter int IOW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  op_kind_t       kind_in,
    input  logic [IOW-1:0] byte_in,
    input  logic [TW-1:0]  t_setup,
    input  logic [TW-1:0]  t_strobe,
    input  logic [TW-1:0]  t_hold,
    input  logic [IOW-1:0] io_in,
    output logic           busy,
    output logic           fin_rd,
    output logic [IOW-1:0] rbyte,
    output logic           cle,
    output logic           ale,
    output logic           nwe,
    output logic           nre,
    output logic           oe,
    output logic [IOW-1:0] io_out
);

    phase_t         phase;
    op_kind_t       kind_q;
    logic [TW-1:0]  cnt;
    logic [TW-1:0]  lat_s, lat_p, lat_h;
    logic [IOW-1:0] byte_q;
    logic           hold_last;

    // Phase progression and per-phase cycle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            kind_q <= OP_CMD;
            cnt    <= '0;
            lat_s  <= '0;
            lat_p  <= '0;
            lat_h  <= '0;
            byte_q <= '0;
            rbyte  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        kind_q <= kind_in;
                        byte_q <= byte_in;
                        lat_s  <= t_setup;
                        lat_p  <= t_strobe;
                        lat_h  <= t_hold;
                        cnt    <= '0;
                        phase  <= (t_setup == '0) ? PH_STROBE : PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == lat_s - TW'(1)) begin
                        cnt   <= '0;
                        phase <= PH_STROBE;
                    end else begin
                        cnt <= cnt + TW'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt == lat_p) begin
                        cnt   <= '0;
                        phase <= PH_HOLD;
                        if (kind_q == OP_RDATA) rbyte <= io_in;
                    end else begin
                        cnt <= cnt + TW'(1);
                    end
                end
                PH_HOLD: begin
                    if (hold_last) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + TW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Pin levels decoded from phase and latched kind.
    always_comb begin
        busy      = (phase != PH_IDLE);
        hold_last = (phase == PH_HOLD) && (cnt == lat_h);
        fin_rd    = hold_last && (kind_q == OP_RDATA);
        cle       = busy && (kind_q == OP_CMD);
        ale       = busy && (kind_q == OP_ADDR);
        oe        = busy && (kind_q != OP_RDATA);
        nwe       = !((phase == PH_STROBE) && (kind_q != OP_RDATA));
        nre       = !((phase == PH_STROBE) && (kind_q == OP_RDATA));
        io_out    = byte_q;
    end

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nwe && !nre));

    assert_latch_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    assert_no_drive_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !nre |-> !oe);

    assert_op_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(byte_q) && $stable(kind_q)));

endmodule

// File: rtl/nand_if_ctrl.sv
// Top level: host register decode, wait control, chip enable and read result.
// Assumes byte offsets on bus_addr and one-cycle bus_sel strobes.
module nand_if_ctrl
    import nand_if_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 8,
    parameter int IOW    = 8,
    parameter int TW     = 3,
    parameter int SYNC_N = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_ready,
    output logic           fl_nce,
    output logic           fl_cle,
    output logic           fl_ale,
    output logic           fl_nwe,
    output logic           fl_nre,
    output logic [IOW-1:0] fl_io_out,
    output logic           fl_io_oe,
    input  logic [IOW-1:0] fl_io_in,
    input  logic           fl_rnb
);

    logic           busy, fin_rd, rnb_s, en, ce_off;
    logic           accept, hit_cfg, hit_ctrl, hit_cmd, hit_addr, hit_data, hit_stat;
    logic           cfg_we, ctrl_we, start;
    logic [TW-1:0]  t_setup, t_strobe, t_hold;
    logic [DW-1:0]  cfg_word, ctrl_word, stat_word, rdata_q;
    logic [IOW-1:0] rbyte;
    op_kind_t       kind_in;

    // Address decode and request classification.
    always_comb begin
        accept   = bus_sel && !busy;
        hit_cfg  = (bus_addr == AW'(OFF_CFG));
        hit_ctrl = (bus_addr == AW'(OFF_CTRL));
        hit_cmd  = (bus_addr == AW'(OFF_CMD));
        hit_addr = (bus_addr == AW'(OFF_ADDR));
        hit_data = (bus_addr == AW'(OFF_DATA));
        hit_stat = (bus_addr == AW'(OFF_STAT));
        cfg_we   = accept && bus_wr && hit_cfg;
        ctrl_we  = accept && bus_wr && hit_ctrl;
        start    = accept && en && (bus_wr ? (hit_cmd || hit_addr || hit_data) : hit_data);
        if (!bus_wr)       kind_in = OP_RDATA;
        else if (hit_cmd)  kind_in = OP_CMD;
        else if (hit_addr) kind_in = OP_ADDR;
        else               kind_in = OP_WDATA;
    end

    nand_if_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (fl_rnb),
        .q     (rnb_s)
    );

    nand_if_regs #(.DW(DW), .TW(TW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .ctrl_we   (ctrl_we),
        .wdata     (bus_wdata),
        .rnb_s     (rnb_s),
        .t_setup   (t_setup),
        .t_strobe  (t_strobe),
        .t_hold    (t_hold),
        .en        (en),
        .ce_off    (ce_off),
        .cfg_word  (cfg_word),
        .ctrl_word (ctrl_word),
        .stat_word (stat_word)
    );

    nand_if_seq #(.TW(TW), .IOW(IOW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind_in  (kind_in),
        .byte_in  (bus_wdata[IOW-1:0]),
        .t_setup  (t_setup),
        .t_strobe (t_strobe),
        .t_hold   (t_hold),
        .io_in    (fl_io_in),
        .busy     (busy),
        .fin_rd   (fin_rd),
        .rbyte    (rbyte),
        .cle      (fl_cle),
        .ale      (fl_ale),
        .nwe      (fl_nwe),
        .nre      (fl_nre),
        .oe       (fl_io_oe),
        .io_out   (fl_io_out)
    );

    // Read result: flash byte at cycle end, register word on immediate reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (fin_rd) begin
            rdata_q <= DW'(rbyte);
        end else if (accept && !bus_wr && !(hit_data && en)) begin
            if (hit_cfg)       rdata_q <= cfg_word;
            else if (hit_ctrl) rdata_q <= ctrl_word;
            else if (hit_stat) rdata_q <= stat_word;
            else               rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_ready = !busy;
    assign fl_nce    = !(en && !ce_off);

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (fl_nwe && fl_nre && fl_nce));

    assert_ready_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fin_rd |=> bus_ready);

endmodule

// File: tb/nand_if_ctrl_bench.sv
// Bench for nand_if_ctrl: behavioural per-cycle pin model plus a small flash model.
module nand_if_ctrl_bench;

    logic        clk, rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ready;
    logic        fl_nce, fl_cle, fl_ale, fl_nwe, fl_nre, fl_io_oe, fl_rnb;
    logic [7:0]  fl_io_out, fl_io_in;

    int vectors = 0;
    int miscompares = 0;
    int ts = 0, tp = 0, th = 0;

    nand_if_ctrl u_nand_if_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .fl_nce(fl_nce), .fl_cle(fl_cle), .fl_ale(fl_ale),
        .fl_nwe(fl_nwe), .fl_nre(fl_nre), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
        .fl_io_in(fl_io_in), .fl_rnb(fl_rnb)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Flash model: identification mode after command 0x90, else a plain byte.
    logic [7:0] id_tab [4];
    logic [7:0] id_idx = 8'd0;
    logic       id_mode = 1'b0;
    logic [7:0] plain_byte = 8'h00;
    initial begin
        id_tab[0] = 8'hEC; id_tab[1] = 8'hDA; id_tab[2] = 8'h10; id_tab[3] = 8'h95;
    end
    assign fl_io_in = id_mode ? id_tab[id_idx[1:0]] : plain_byte;
    always @(posedge fl_nwe) if (fl_cle === 1'b1) begin
        id_mode <= (fl_io_out == 8'h90);
        id_idx  <= 8'd0;
    end
    always @(posedge fl_nre) id_idx <= id_idx + 8'd1;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One-cycle host strobe; returns at the negedge after the accepting edge.
    task automatic bus_cycle(input logic wr, input logic [7:0] off, input logic [31:0] wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = off; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] off, input logic [31:0] wd);
        bus_cycle(1'b1, off, wd);
    endtask

    task automatic reg_rd(input string tag, input logic [7:0] off, input logic [31:0] exp);
        bus_cycle(1'b0, off, 32'h0);
        chk(tag, "ready", {31'h0, bus_ready}, 32'h1);
        chk(tag, "rdata", bus_rdata, exp);
    endtask

    task automatic set_timing(input int s, input int p, input int h);
        ts = s; tp = p; th = h;
        reg_wr(8'h00, (s << 12) | (p << 8) | (h << 4));
    endtask

    // Issue a flash access and compare every pin on every cycle against the model.
    task automatic flash_op(input string tag, input logic wr, input logic [7:0] off,
                            input logic [7:0] b, input logic [7:0] exp_rd, input bit inject);
        int n = ts + tp + th + 2;
        bit is_cmd = wr && (off == 8'h08);
        bit is_adr = wr && (off == 8'h0C);
        bus_cycle(wr, off, {24'hABCDEF, b});
        for (int j = 0; j <= n; j++) begin
            bit bz = (j < n);
            bit stb = bz && (j >= ts) && (j < ts + tp + 1);
            chk(tag, "cle", {31'h0, fl_cle}, {31'h0, bz && is_cmd});
            chk(tag, "ale", {31'h0, fl_ale}, {31'h0, bz && is_adr});
            chk(tag, "nwe", {31'h0, fl_nwe}, {31'h0, !(stb && wr)});
            chk(tag, "nre", {31'h0, fl_nre}, {31'h0, !(stb && !wr)});
            chk(tag, "oe", {31'h0, fl_io_oe}, {31'h0, bz && wr});
            chk(tag, "ready", {31'h0, bus_ready}, {31'h0, !bz});
            if (bz && wr) chk(tag, "io_out", {24'h0, fl_io_out}, {24'h0, b});
            if (!bz && !wr) chk(tag, "rdata", bus_rdata, {24'h0, exp_rd});
            if (inject && j == 1) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h55;
            end
            if (inject && j == 2) bus_sel = 1'b0;
            if (j < n) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0;
        bus_wdata = 32'h0; fl_rnb = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "nce", {31'h0, fl_nce}, 32'h1);
        chk("R1", "nwe", {31'h0, fl_nwe}, 32'h1);
        chk("R1", "nre", {31'h0, fl_nre}, 32'h1);
        chk("R1", "cle", {31'h0, fl_cle}, 32'h0);
        chk("R1", "ale", {31'h0, fl_ale}, 32'h0);
        chk("R1", "oe", {31'h0, fl_io_oe}, 32'h0);
        chk("R1", "ready", {31'h0, bus_ready}, 32'h1);
        reg_rd("R1", 8'h00, 32'h0);
        reg_rd("R1", 8'h04, 32'h2);

        // R3 timing fields readback, reserved bits read 0
        reg_wr(8'h00, 32'hFFFF_FFFF);
        reg_rd("R3", 8'h00, 32'h0000_7770);
        set_timing(2, 1, 0);
        reg_rd("R3", 8'h00, 32'h0000_2100);

        // R2 chip enable and controller enable
        reg_wr(8'h04, 32'h1);
        chk("R2", "nce", {31'h0, fl_nce}, 32'h0);
        reg_wr(8'h04, 32'hFFFF_FFFF);
        chk("R2", "nce", {31'h0, fl_nce}, 32'h1);
        reg_rd("R2", 8'h04, 32'h3);
        reg_wr(8'h04, 32'h1);
        chk("R2", "nce", {31'h0, fl_nce}, 32'h0);

        // R4 R5 R12 identification sequence
        flash_op("R4", 1'b1, 8'h08, 8'h90, 8'h00, 1'b0);
        flash_op("R5", 1'b1, 8'h0C, 8'h00, 8'h00, 1'b0);
        flash_op("R12", 1'b0, 8'h10, 8'h00, 8'hEC, 1'b0);
        flash_op("R12", 1'b0, 8'h10, 8'h00, 8'hDA, 1'b0);
        flash_op("R12", 1'b0, 8'h10, 8'h00, 8'h10, 1'b0);
        flash_op("R12", 1'b0, 8'h10, 8'h00, 8'h95, 1'b0);

        // R7 plain read with upper bits zero
        flash_op("R4", 1'b1, 8'h08, 8'h00, 8'h00, 1'b0);
        plain_byte = 8'h5A;
        flash_op("R7", 1'b0, 8'h10, 8'h00, 8'h5A, 1'b0);

        // R6 R8 long timing
        set_timing(7, 7, 7);
        flash_op("R6", 1'b1, 8'h10, 8'hC3, 8'h00, 1'b0);
        plain_byte = 8'hA7;
        flash_op("R8", 1'b0, 8'h10, 8'h00, 8'hA7, 1'b0);

        // R8 minimum timing
        set_timing(0, 0, 0);
        flash_op("R8", 1'b1, 8'h0C, 8'h3E, 8'h00, 1'b0);
        plain_byte = 8'h01;
        flash_op("R8", 1'b0, 8'h10, 8'h00, 8'h01, 1'b0);

        // R8 R9 mixed timing, strobe injected while busy
        set_timing(1, 3, 2);
        flash_op("R9", 1'b1, 8'h08, 8'hE1, 8'h00, 1'b1);
        for (int k = 0; k < 5; k++) begin
            chk("R9", "cle", {31'h0, fl_cle}, 32'h0);
            chk("R9", "nwe", {31'h0, fl_nwe}, 32'h1);
            chk("R9", "ready", {31'h0, bus_ready}, 32'h1);
            @(negedge clk);
        end

        // R11 ready/busy status
        fl_rnb = 1'b0;
        repeat (3) @(negedge clk);
        reg_rd("R11", 8'h20, 32'h0);
        fl_rnb = 1'b1;
        repeat (3) @(negedge clk);
        reg_rd("R11", 8'h20, 32'h1);

        // R10 disabled: no pin activity, no wait, data read returns 0
        reg_wr(8'h04, 32'h0);
        chk("R10", "nce", {31'h0, fl_nce}, 32'h1);
        bus_cycle(1'b1, 8'h08, 32'h90);
        for (int k = 0; k < 8; k++) begin
            chk("R10", "cle", {31'h0, fl_cle}, 32'h0);
            chk("R10", "nwe", {31'h0, fl_nwe}, 32'h1);
            chk("R10", "oe", {31'h0, fl_io_oe}, 32'h0);
            chk("R10", "ready", {31'h0, bus_ready}, 32'h1);
            @(negedge clk);
        end
        plain_byte = 8'h77;
        bus_cycle(1'b0, 8'h10, 32'h0);
        for (int k = 0; k < 6; k++) begin
            chk("R10", "nre", {31'h0, fl_nre}, 32'h1);
            chk("R10", "ready", {31'h0, bus_ready}, 32'h1);
            chk("R10", "rdata", bus_rdata, 32'h0);
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule